// File: doc/BRIEF.md
# Sticky Interrupt Status Register with Collision Counter

This block gathers eight event sources from an Ethernet MAC into one 8-bit interrupt status byte. A bit sets when its event pulse arrives and stays set until the host reads the status byte. That read returns the latched value and clears it in the same cycle. A per-bit mask register decides which set bits drive the active-high interrupt line. At reset every bit is masked.

The block also counts received frames that suffered a collision. The raw count wraps from 255 to 0, and each wrap raises the collision-count overflow status bit. A second copy of the count is meant for per-frame receive status. It stops at 255 and does not wrap. The host reaches all four registers over a small bus with an address, a read strobe, a write strobe and a registered read-data output. Both the hardware reset input and the software reset input return the whole block to its reset state.

Top module: `irq_status_ctrl`

## Requirements
- R1: Status bit positions, bit 7 down to bit 0, are: jabber, babble, collision error, receive collision count overflow, runt count overflow, missed packet count overflow, receive interrupt, transmit interrupt. A pulse on `evt_in[i]` sets status bit i for every i except 4.
- R2: A set status bit stays set on every cycle without a status read.
- R3: A read at address 0 returns the status byte on `rd_data` after the clock edge that samples `rd_en`, and clears the status bits at that same edge. An event that arrives in the read cycle leaves its bit set after the read.
- R4: A write to address 0 has no effect on the status byte. `evt_in[4]` has no effect, because bit 4 is driven only by the collision counter.
- R5: `irq` is high exactly when some status bit is 1 and its mask bit is 0. It follows the registered status and mask with no added cycle.
- R6: The mask register is at address 1. It can be written and read back, and it resets to 8'hFF.
- R7: The collision counter is read at address 2. It adds one for each `coll_frame` pulse and wraps from 255 to 0. That wrap sets status bit 4.
- R8: The frame collision report is read at address 3. It follows the same pulses but saturates at 255.
- R9: `rst` and `sw_rst` each clear the status byte and both counts, and set the mask to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous active-high software reset |
| evt_in | input | 8 | Event pulses, one per status bit (bit 4 unused) |
| coll_frame | input | 1 | Pulse per received frame that suffered a collision |
| addr | input | 2 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench sweeps all 256 mask values against a single pending event on every externally driven bit. A wrong mask polarity or a swapped bit would show up as an `irq` that fires or stays quiet on the wrong combination. It drives an event in the same cycle as a status read. A design that clears before it merges the new event would lose that event, and the following read would return zero. It pushes the collision counter across the 255 boundary and checks that status bit 4 sets only on the wrap, while the report copy stays at 255. Writes to the status address and pulses on `evt_in[4]` are checked to leave the status byte unchanged.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ST_W   = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 2'd1;
  localparam logic [ADDR_W-1:0] A_COLL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_REPORT = 2'd3;
  // status bit positions
  localparam int B_TXINT   = 0;
  localparam int B_RXINT   = 1;
  localparam int B_MISSOVF = 2;
  localparam int B_RUNTOVF = 3;
  localparam int B_COLLOVF = 4;
  localparam int B_CERR    = 5;
  localparam int B_BABBLE  = 6;
  localparam int B_JABBER  = 7;
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         clr_all,
  input  logic [N-1:0] set_vec,
  input  logic         rd_clr,
  output logic [N-1:0] stat_q
);
  // each bit: event wins over a simultaneous read-clear
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (clr_all)        stat_q[i] <= 1'b0;
      else if (set_vec[i]) stat_q[i] <= 1'b1;
      else if (rd_clr)     stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/coll_counter.sv
module coll_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_all,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] sat_q,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  assign wrap = inc && (cnt_q == MAXV);

  always_ff @(posedge clk) begin
    if (clr_all) begin
      cnt_q <= '0;
      sat_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
      if (sat_q != MAXV) sat_q <= sat_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_readmux.sv
module irq_readmux
  import irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              clr_all,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ST_W-1:0]   stat,
  input  logic [ST_W-1:0]   mask,
  input  logic [W-1:0]      cnt,
  input  logic [W-1:0]      sat,
  output logic [ST_W-1:0]   rd_data_q
);
  logic [ST_W-1:0] sel;

  always_comb begin
    unique case (addr)
      A_STATUS: sel = stat;
      A_MASK:   sel = mask;
      A_COLL:   sel = ST_W'(cnt);
      default:  sel = ST_W'(sat);
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr_all)    rd_data_q <= '0;
    else if (rd_en) rd_data_q <= sel;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic [ST_W-1:0]   evt_in,
  input  logic              coll_frame,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ST_W-1:0]   wr_data,
  output logic [ST_W-1:0]   rd_data,
  output logic              irq
);
  logic              clr_all;
  logic              coll_wrap;
  logic              stat_rd;
  logic [ST_W-1:0]   evt_all;
  logic [ST_W-1:0]   stat_q;
  logic [ST_W-1:0]   mask_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  sat_q;

  assign clr_all = rst | sw_rst;
  assign stat_rd = rd_en && (addr == A_STATUS);

  always_comb begin
    evt_all           = evt_in;
    evt_all[B_COLLOVF] = coll_wrap;
  end

  always_ff @(posedge clk) begin
    if (clr_all)                        mask_q <= '1;
    else if (wr_en && addr == A_MASK)   mask_q <= wr_data;
  end

  irq_status_bits #(.N(ST_W)) i_bits (
    .clk(clk), .clr_all(clr_all), .set_vec(evt_all),
    .rd_clr(stat_rd), .stat_q(stat_q)
  );

  coll_counter #(.W(CNT_W)) i_coll (
    .clk(clk), .clr_all(clr_all), .inc(coll_frame),
    .cnt_q(cnt_q), .sat_q(sat_q), .wrap(coll_wrap)
  );

  irq_readmux #(.W(CNT_W)) i_mux (
    .clk(clk), .clr_all(clr_all), .rd_en(rd_en), .addr(addr),
    .stat(stat_q), .mask(mask_q), .cnt(cnt_q), .sat(sat_q),
    .rd_data_q(rd_data)
  );

  assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_rst,
  input logic             stat_rd,
  input logic             coll_frame,
  input logic [ST_W-1:0]  evt_all,
  input logic [ST_W-1:0]  stat_q,
  input logic [ST_W-1:0]  mask_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] sat_q,
  input logic             irq
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  a_r2_sticky: assert property (@(posedge clk) disable iff (rst || sw_rst)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (stat_rd && evt_all == '0) |=> stat_q == '0);

  a_r3_event_kept: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (stat_rd && evt_all[B_JABBER]) |=> stat_q[B_JABBER]);

  a_r5_all_masked: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (mask_q == '1) |-> !irq);

  a_r9_reset_state: assert property (@(posedge clk)
    (rst || sw_rst) |=> (mask_q == '1 && stat_q == '0 && cnt_q == '0));

  a_r7_wrap: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (coll_frame && cnt_q == MAXV) |=> (cnt_q == '0 && stat_q[B_COLLOVF]));

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (sat_q == MAXV) |=> sat_q == MAXV);
endmodule

bind irq_status_ctrl irq_status_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .stat_rd(stat_rd),
  .coll_frame(coll_frame), .evt_all(evt_all), .stat_q(stat_q),
  .mask_q(mask_q), .cnt_q(cnt_q), .sat_q(sat_q), .irq(irq)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_rst = 1'b0;
  logic [7:0] evt_in = '0;
  logic       coll_frame = 1'b0;
  logic [1:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .evt_in(evt_in),
    .coll_frame(coll_frame), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic colls(input int n);
    for (int k = 0; k < n; k++) begin
      coll_frame = 1'b1;
      @(negedge clk);
    end
    coll_frame = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(2'd0, d); check("R9 status after reset", d, 8'h00);
    rd(2'd1, d); check("R6 mask after reset", d, 8'hFF);
    check("R5 irq after reset", {7'd0, irq}, 8'h00);

    // R1/R2/R3: each bit latches, survives idle, read clears
    for (int b = 0; b < 8; b++) begin
      if (b == 4) continue;
      pulse(8'(1 << b));
      repeat (3) @(negedge clk);
      rd(2'd0, d); check("R1 R2 bit latch", d, 8'(1 << b));
      rd(2'd0, d); check("R3 cleared by read", d, 8'h00);
    end

    // R4: evt_in[4] ignored, writes to status ignored
    pulse(8'h10);
    rd(2'd0, d); check("R4 evt_in bit4 ignored", d, 8'h00);
    pulse(8'h40);
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R4 status write ignored", d, 8'h40);

    // R3: event in read cycle is kept
    pulse(8'h80);
    evt_in = 8'h01;
    rd(2'd0, d);
    evt_in = '0;
    check("R3 read returns old", d, 8'h80);
    rd(2'd0, d); check("R3 same-cycle event kept", d, 8'h01);

    // R5/R6: exhaustive mask sweep
    for (int m = 0; m < 256; m++) begin
      wr(2'd1, 8'(m));
      if (m % 37 == 0) begin
        rd(2'd1, d); check("R6 mask readback", d, 8'(m));
      end
      for (int b = 0; b < 8; b++) begin
        if (b == 4) continue;
        pulse(8'(1 << b));
        check("R5 irq vs mask", {7'd0, irq}, {7'd0, ~m[b]});
        rd(2'd0, d);
        check("R5 irq drops after read", {7'd0, irq}, 8'h00);
      end
    end

    // R7/R8: collision counter boundary
    wr(2'd1, 8'hEF);
    colls(255);
    rd(2'd2, d); check("R7 count 255", d, 8'd255);
    rd(2'd3, d); check("R8 report 255", d, 8'd255);
    rd(2'd0, d); check("R7 no overflow before wrap", d, 8'h00);
    check("R5 irq idle", {7'd0, irq}, 8'h00);
    colls(1);
    check("R5 irq on overflow", {7'd0, irq}, 8'h01);
    rd(2'd2, d); check("R7 count wraps to 0", d, 8'd0);
    rd(2'd3, d); check("R8 report frozen", d, 8'd255);
    rd(2'd0, d); check("R7 overflow bit 4", d, 8'h10);
    colls(44);
    rd(2'd2, d); check("R7 count after wrap", d, 8'd44);
    rd(2'd3, d); check("R8 report still 255", d, 8'd255);
    rd(2'd0, d); check("R7 single overflow", d, 8'h00);

    // R9: software reset
    wr(2'd1, 8'h00);
    pulse(8'hE3);
    sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0;
    check("R9 irq after sw reset", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R9 status after sw reset", d, 8'h00);
    rd(2'd1, d); check("R9 mask after sw reset", d, 8'hFF);
    rd(2'd2, d); check("R9 count after sw reset", d, 8'h00);
    rd(2'd3, d); check("R9 report after sw reset", d, 8'h00);

    // R9: hardware reset
    colls(3); pulse(8'h21);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(2'd0, d); check("R9 status after rst", d, 8'h00);
    rd(2'd2, d); check("R9 count after rst", d, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule